// File: doc/BRIEF.md
# Single-Port Bank Group Write Deferral Arbiter

This block stands between a compute array's read and write request streams and a result buffer built from single-port bank groups. Each group can serve one access per cycle. The block never issues a read and a write to the same group in the same cycle. A read always goes to its group at once. A write is sent straight to its group when that group is free. When the write would collide, it is parked in one of two holding slots and written on a later cycle, once its group is idle. The array is never stalled by ordinary collisions.

A read returns its data one cycle after the request. If a parked write still covers some lanes of the row being read, the read takes those lanes from the slot and not from the bank. The bank storage and the address mapping sit outside this block. The `busy` output refuses an incoming write in only two cases: when all storage is exhausted, and during a drain.

Top module: `wdf_handler`

## Requirements
- R1: No bank group ever sees `bank_rd_en` and `bank_wr_en` high in the same cycle.
- R2: A valid read drives `bank_rd_en` of its group, and the group's row bus carries `rd_row`, in the same cycle.
- R3: An accepted write whose group is neither read nor taken by a retiring parked write is issued in the same cycle. Its group's row, data and lane mask buses carry the request.
- R4: A write that collides is parked in the newer slot and issued on the next cycle if its group is then free. A run of collisions that moves from group to group forms a steady one-cycle-delayed write stream.
- R5: A parked write that cannot retire is moved to the older slot. The cause may be a read to its group or an older parked write to the same group. Older parked writes always retire before newer ones, so a later write to the same row is never overwritten by an earlier one.
- R6: `rd_data_vld` rises exactly one cycle after a valid read. `rd_data` is zero in every lane whose `rd_mask` bit is clear. Lane i is bits [8i+7:8i].
- R7: `rd_data` equals the row contents as left by every write accepted before the read cycle. Lanes held in parked slots are taken from the slots, and the newer slot wins over the older one. A write accepted in the same cycle as the read is not visible to that read.
- R8: `busy` rises, and the incoming write is dropped, when both slots hold writes that cannot retire this cycle and the incoming write also collides.
- R9: While `drain` is high and no read is valid, `busy` refuses incoming writes as long as any slot is occupied. After two such cycles both slots are empty.
- R10: During and right after reset, all bank enables, `busy` and `rd_data_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_vld | input | 1 | Read request valid |
| rd_grp | input | 2 | Read bank group |
| rd_row | input | 4 | Read row within the group |
| rd_mask | input | 4 | Read lane mask |
| wr_vld | input | 1 | Write request valid |
| wr_grp | input | 2 | Write bank group |
| wr_row | input | 4 | Write row |
| wr_mask | input | 4 | Write lane enables |
| wr_data | input | 32 | Write data |
| drain | input | 1 | Empty the parked writes, refusing new writes meanwhile |
| busy | output | 1 | Incoming write refused this cycle |
| rd_data_vld | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, masked and merged |
| bank_rd_en | output | 4 | Per-group read enable |
| bank_wr_en | output | 4 | Per-group write enable |
| bank_row | output | 16 | Per-group row, 4 bits each |
| bank_wmask | output | 16 | Per-group lane write enables |
| bank_wdata | output | 128 | Per-group write data |
| bank_rdata | input | 128 | Per-group read data, valid the cycle after a read enable |

## Verification
Enables, row, data and `busy` are combinational results of the current request and the slot state. The bench reads them in the middle of the same cycle, before the edge that takes the request. A parked write appears at the bank one cycle after its collision, or two cycles after it when it was pushed to the older slot. The directed sequences check each of those cycles, and also check that the write is absent from the cycles in between. Read data is due one cycle after the request, because of the bank's output register and the block's forward register. It is compared in the middle of that next cycle against a shadow array that is updated only by accepted writes, after the read's expected value has been captured.

// File: rtl/wdf_pkg.sv
package wdf_pkg;

    parameter int GROUPS = 4;
    parameter int ROW_W  = 4;
    parameter int LANE_W = 8;
    parameter int LANES  = 4;

    localparam int DATA_W = LANE_W * LANES;
    localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;

    typedef struct packed {
        logic             vld;
        logic [GRP_W-1:0] grp;
        logic [ROW_W-1:0] row;
        logic [LANES-1:0] mask;
        logic [DATA_W-1:0] data;
    } wr_ent_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_OLD,
        SRC_NEW,
        SRC_IN
    } wsrc_e;

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] base,
        input logic [DATA_W-1:0] upd,
        input logic [LANES-1:0]  sel
    );
        logic [DATA_W-1:0] r;
        r = base;
        for (int i = 0; i < LANES; i++) begin
            if (sel[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

    function automatic logic ent_hits(
        input wr_ent_t          e,
        input logic [GRP_W-1:0] grp,
        input logic [ROW_W-1:0] row
    );
        return e.vld && (e.grp == grp) && (e.row == row);
    endfunction

endpackage

// File: rtl/wdf_arbiter.sv
module wdf_arbiter
    import wdf_pkg::*;
(
    input  logic             rd_vld,
    input  logic [GRP_W-1:0] rd_grp,
    input  logic             drain,
    input  wr_ent_t          ent_in,
    input  wr_ent_t          hold_old,
    input  wr_ent_t          hold_new,
    output logic             old_go,
    output logic             new_go,
    output logic             in_go,
    output logic             busy,
    output wr_ent_t          nxt_old,
    output wr_ent_t          nxt_new
);
    logic old_left, new_left, in_clash, in_acc, in_left;

    always_comb begin
        // oldest first: a parked write only yields to the read or to an older write
        old_go   = hold_old.vld && !(rd_vld && hold_old.grp == rd_grp);
        new_go   = hold_new.vld && !(rd_vld && hold_new.grp == rd_grp)
                   && !(old_go && hold_old.grp == hold_new.grp);
        old_left = hold_old.vld && !old_go;
        new_left = hold_new.vld && !new_go;
        in_clash = (rd_vld && ent_in.grp == rd_grp)
                   || (old_go && hold_old.grp == ent_in.grp)
                   || (new_go && hold_new.grp == ent_in.grp);
        busy     = ent_in.vld && ((old_left && new_left && in_clash)
                   || (drain && !rd_vld && (hold_old.vld || hold_new.vld)));
        in_acc   = ent_in.vld && !busy;
        in_go    = in_acc && !in_clash;
        in_left  = in_acc && in_clash;

        // survivors are repacked by age: older slot first
        nxt_old = '0;
        nxt_new = '0;
        if (old_left) begin
            nxt_old = hold_old;
            if (new_left)     nxt_new = hold_new;
            else if (in_left) nxt_new = ent_in;
        end else if (new_left) begin
            nxt_old = hold_new;
            if (in_left) nxt_new = ent_in;
        end else if (in_left) begin
            nxt_new = ent_in;
        end
    end
endmodule

// File: rtl/wdf_hold.sv
module wdf_hold
    import wdf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_ent_t nxt_old,
    input  wr_ent_t nxt_new,
    output wr_ent_t hold_old,
    output wr_ent_t hold_new
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_old <= '0;
            hold_new <= '0;
        end else begin
            hold_old <= nxt_old;
            hold_new <= nxt_new;
        end
    end
endmodule

// File: rtl/wdf_rdfwd.sv
module wdf_rdfwd
    import wdf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_vld,
    input  logic [GRP_W-1:0]         rd_grp,
    input  logic [ROW_W-1:0]         rd_row,
    input  logic [LANES-1:0]         rd_mask,
    input  wr_ent_t                  hold_old,
    input  wr_ent_t                  hold_new,
    input  logic [GROUPS*DATA_W-1:0] bank_rdata,
    output logic                     rd_data_vld,
    output logic [DATA_W-1:0]        rd_data
);
    logic [LANES-1:0]  fwd_sel, q_sel, q_mask;
    logic [DATA_W-1:0] fwd_dat, q_dat, base;
    logic [GRP_W-1:0]  q_grp;
    logic              q_vld;
    logic [DATA_W-1:0] grp_word [GROUPS];

    for (genvar g = 0; g < GROUPS; g++) begin : g_word
        assign grp_word[g] = bank_rdata[g*DATA_W +: DATA_W];
    end

    always_comb begin
        fwd_sel = '0;
        fwd_dat = '0;
        if (ent_hits(hold_old, rd_grp, rd_row)) begin
            fwd_dat = lane_merge(fwd_dat, hold_old.data, hold_old.mask);
            fwd_sel = fwd_sel | hold_old.mask;
        end
        if (ent_hits(hold_new, rd_grp, rd_row)) begin
            fwd_dat = lane_merge(fwd_dat, hold_new.data, hold_new.mask);
            fwd_sel = fwd_sel | hold_new.mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld  <= 1'b0;
            q_grp  <= '0;
            q_mask <= '0;
            q_sel  <= '0;
            q_dat  <= '0;
        end else begin
            q_vld  <= rd_vld;
            q_grp  <= rd_grp;
            q_mask <= rd_mask;
            q_sel  <= fwd_sel;
            q_dat  <= fwd_dat;
        end
    end

    assign base        = grp_word[q_grp];
    assign rd_data_vld = q_vld;
    assign rd_data     = q_vld ? lane_merge('0, lane_merge(base, q_dat, q_sel), q_mask) : '0;
endmodule

// File: rtl/wdf_handler.sv
module wdf_handler
    import wdf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_vld,
    input  logic [GRP_W-1:0]         rd_grp,
    input  logic [ROW_W-1:0]         rd_row,
    input  logic [LANES-1:0]         rd_mask,
    input  logic                     wr_vld,
    input  logic [GRP_W-1:0]         wr_grp,
    input  logic [ROW_W-1:0]         wr_row,
    input  logic [LANES-1:0]         wr_mask,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     drain,
    output logic                     busy,
    output logic                     rd_data_vld,
    output logic [DATA_W-1:0]        rd_data,
    output logic [GROUPS-1:0]        bank_rd_en,
    output logic [GROUPS-1:0]        bank_wr_en,
    output logic [GROUPS*ROW_W-1:0]  bank_row,
    output logic [GROUPS*LANES-1:0]  bank_wmask,
    output logic [GROUPS*DATA_W-1:0] bank_wdata,
    input  logic [GROUPS*DATA_W-1:0] bank_rdata
);
    wr_ent_t ent_in, hold_old, hold_new, nxt_old, nxt_new;
    logic    old_go, new_go, in_go;

    assign ent_in = '{vld: wr_vld, grp: wr_grp, row: wr_row, mask: wr_mask, data: wr_data};

    wdf_arbiter u_arb (
        .rd_vld   (rd_vld),
        .rd_grp   (rd_grp),
        .drain    (drain),
        .ent_in   (ent_in),
        .hold_old (hold_old),
        .hold_new (hold_new),
        .old_go   (old_go),
        .new_go   (new_go),
        .in_go    (in_go),
        .busy     (busy),
        .nxt_old  (nxt_old),
        .nxt_new  (nxt_new)
    );

    wdf_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .nxt_old  (nxt_old),
        .nxt_new  (nxt_new),
        .hold_old (hold_old),
        .hold_new (hold_new)
    );

    wdf_rdfwd u_rdfwd (
        .clk         (clk),
        .rst         (rst),
        .rd_vld      (rd_vld),
        .rd_grp      (rd_grp),
        .rd_row      (rd_row),
        .rd_mask     (rd_mask),
        .hold_old    (hold_old),
        .hold_new    (hold_new),
        .bank_rdata  (bank_rdata),
        .rd_data_vld (rd_data_vld),
        .rd_data     (rd_data)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_bank
        wsrc_e   src;
        wr_ent_t sel;

        always_comb begin
            if (old_go && hold_old.grp == GRP_W'(g))      src = SRC_OLD;
            else if (new_go && hold_new.grp == GRP_W'(g)) src = SRC_NEW;
            else if (in_go && ent_in.grp == GRP_W'(g))    src = SRC_IN;
            else                                          src = SRC_NONE;
            case (src)
                SRC_OLD: sel = hold_old;
                SRC_NEW: sel = hold_new;
                SRC_IN:  sel = ent_in;
                default: sel = '0;
            endcase
        end

        assign bank_rd_en[g]                  = rd_vld && (rd_grp == GRP_W'(g));
        assign bank_wr_en[g]                  = (src != SRC_NONE);
        assign bank_row[g*ROW_W +: ROW_W]     = bank_rd_en[g] ? rd_row : sel.row;
        assign bank_wmask[g*LANES +: LANES]   = sel.mask;
        assign bank_wdata[g*DATA_W +: DATA_W] = sel.data;
    end
endmodule

// File: rtl/wdf_checker.sv
module wdf_checker
    import wdf_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    rd_vld,
    input logic [GRP_W-1:0]        rd_grp,
    input logic [ROW_W-1:0]        rd_row,
    input logic                    wr_vld,
    input logic                    drain,
    input logic                    busy,
    input logic                    rd_data_vld,
    input logic [GROUPS-1:0]       bank_rd_en,
    input logic [GROUPS-1:0]       bank_wr_en,
    input logic [GROUPS*ROW_W-1:0] bank_row,
    input wr_ent_t                 hold_old,
    input wr_ent_t                 hold_new
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assert_no_rw_clash_R1: assert property (@(posedge clk) disable iff (rst)
            !(bank_rd_en[g] && bank_wr_en[g]));
    end

    assert_read_issued_R2: assert property (@(posedge clk) disable iff (rst)
        rd_vld |-> (bank_rd_en[rd_grp] && bank_row[rd_grp*ROW_W +: ROW_W] == rd_row));

    assert_read_return_R6: assert property (@(posedge clk) disable iff (rst)
        rd_vld |=> rd_data_vld);

    assert_no_spurious_return_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_vld |=> !rd_data_vld);

    assert_busy_needs_write_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> wr_vld);

    assert_drain_empties_R9: assert property (@(posedge clk) disable iff (rst)
        (drain && !rd_vld && $past(drain && !rd_vld)) |=> (!hold_old.vld && !hold_new.vld));
endmodule

bind wdf_handler wdf_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_vld      (rd_vld),
    .rd_grp      (rd_grp),
    .rd_row      (rd_row),
    .wr_vld      (wr_vld),
    .drain       (drain),
    .busy        (busy),
    .rd_data_vld (rd_data_vld),
    .bank_rd_en  (bank_rd_en),
    .bank_wr_en  (bank_wr_en),
    .bank_row    (bank_row),
    .hold_old    (hold_old),
    .hold_new    (hold_new)
);

// File: tb/wdf_handler_test.sv
module wdf_handler_test;
    import wdf_pkg::*;

    localparam int CLK_P = 10;
    localparam int ROWS  = 1 << ROW_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_vld = 0, wr_vld = 0, drain = 0;
    logic [GRP_W-1:0] rd_grp = '0, wr_grp = '0;
    logic [ROW_W-1:0] rd_row = '0, wr_row = '0;
    logic [LANES-1:0] rd_mask = '0, wr_mask = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic busy, rd_data_vld;
    logic [DATA_W-1:0] rd_data;
    logic [GROUPS-1:0] bank_rd_en, bank_wr_en;
    logic [GROUPS*ROW_W-1:0] bank_row;
    logic [GROUPS*LANES-1:0] bank_wmask;
    logic [GROUPS*DATA_W-1:0] bank_wdata, bank_rdata;

    always #(CLK_P/2) clk = ~clk;

    wdf_handler uut (
        .clk(clk), .rst(rst), .rd_vld(rd_vld), .rd_grp(rd_grp), .rd_row(rd_row),
        .rd_mask(rd_mask), .wr_vld(wr_vld), .wr_grp(wr_grp), .wr_row(wr_row),
        .wr_mask(wr_mask), .wr_data(wr_data), .drain(drain), .busy(busy),
        .rd_data_vld(rd_data_vld), .rd_data(rd_data), .bank_rd_en(bank_rd_en),
        .bank_wr_en(bank_wr_en), .bank_row(bank_row), .bank_wmask(bank_wmask),
        .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
    );

    function automatic logic [DATA_W-1:0] mix(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b,
                                              input logic [LANES-1:0] m);
        logic [DATA_W-1:0] keep;
        keep = '0;
        for (int i = 0; i < LANES; i++) if (m[i]) keep |= {LANE_W{1'b1}} << (i*LANE_W);
        return (a & ~keep) | (b & keep);
    endfunction

    // single-port bank model with registered read output
    logic [DATA_W-1:0] mem [GROUPS][ROWS];
    logic [DATA_W-1:0] rdq [GROUPS];
    always_ff @(posedge clk) begin
        for (int g = 0; g < GROUPS; g++) begin
            if (rst) begin
                rdq[g] <= '0;
                for (int r = 0; r < ROWS; r++) mem[g][r] <= '0;
            end else begin
                if (bank_wr_en[g])
                    mem[g][bank_row[g*ROW_W +: ROW_W]] <= mix(mem[g][bank_row[g*ROW_W +: ROW_W]],
                        bank_wdata[g*DATA_W +: DATA_W], bank_wmask[g*LANES +: LANES]);
                if (bank_rd_en[g]) rdq[g] <= mem[g][bank_row[g*ROW_W +: ROW_W]];
            end
        end
    end
    always_comb for (int g = 0; g < GROUPS; g++) bank_rdata[g*DATA_W +: DATA_W] = rdq[g];

    logic [DATA_W-1:0] shadow [GROUPS][ROWS];
    int n_chk = 0, n_fail = 0;
    logic exp_pend = 0;
    logic [DATA_W-1:0] exp_data = '0;
    logic snap_busy;
    logic [GROUPS-1:0] snap_wr, snap_rd;
    logic [GROUPS*ROW_W-1:0] snap_row;
    logic [GROUPS*DATA_W-1:0] snap_wdata;
    logic [31:0] lf = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic rv, input int rg, input int rr, input logic [LANES-1:0] rm,
                       input logic wv, input int wg, input int wr, input logic [LANES-1:0] wm,
                       input logic [DATA_W-1:0] wd, input logic dr);
        rd_vld = rv; rd_grp = GRP_W'(rg); rd_row = ROW_W'(rr); rd_mask = rm;
        wr_vld = wv; wr_grp = GRP_W'(wg); wr_row = ROW_W'(wr); wr_mask = wm; wr_data = wd;
        drain = dr;
        @(negedge clk);
        if (exp_pend) chk(rd_data_vld && rd_data == exp_data, "R7 read data", {31'd0, rd_data_vld, rd_data}, {32'd1, exp_data});
        else          chk(!rd_data_vld, "R6 no return", {63'd0, rd_data_vld}, 64'd0);
        chk((bank_rd_en & bank_wr_en) == '0, "R1 clash", {60'd0, bank_rd_en & bank_wr_en}, 64'd0);
        if (rv) chk(bank_rd_en[rg] && bank_row[rg*ROW_W +: ROW_W] == ROW_W'(rr), "R2 read issue",
                    {59'd0, bank_rd_en[rg], bank_row[rg*ROW_W +: ROW_W]}, {59'd1, ROW_W'(rr)});
        snap_busy = busy; snap_wr = bank_wr_en; snap_rd = bank_rd_en;
        snap_row = bank_row; snap_wdata = bank_wdata;
        exp_pend = rv;
        exp_data = rv ? mix('0, shadow[rg][rr], rm) : '0;
        if (wv && !busy) shadow[wg][wr] = mix(shadow[wg][wr], wd, wm);
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 0, 0, 0, '0, '0, 0);
    endtask

    task automatic chk_wr(input int g, input logic en, input int row, input string req);
        chk(snap_wr[g] == en, req, {63'd0, snap_wr[g]}, {63'd0, en});
        if (en) chk(snap_row[g*ROW_W +: ROW_W] == ROW_W'(row), req,
                    {60'd0, snap_row[g*ROW_W +: ROW_W]}, {60'd0, ROW_W'(row)});
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int g = 0; g < GROUPS; g++) for (int r = 0; r < ROWS; r++) shadow[g][r] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(bank_rd_en == '0 && bank_wr_en == '0 && !busy && !rd_data_vld, "R10 reset state",
            {56'd0, bank_rd_en, bank_wr_en}, 64'd0);
        @(posedge clk); #1;

        // R3: free group, direct write
        cyc(0, 0, 0, '0, 1, 2, 5, 4'hF, 32'hA5A5_0001, 0);
        chk_wr(2, 1, 5, "R3 direct write");
        chk(snap_wdata[2*DATA_W +: DATA_W] == 32'hA5A5_0001, "R3 write data",
            {32'd0, snap_wdata[2*DATA_W +: DATA_W]}, 64'hA5A5_0001);

        // R4: collisions walking across groups
        cyc(1, 1, 0, 4'hF, 1, 1, 3, 4'hF, 32'h1111_0003, 0);
        chk_wr(1, 0, 0, "R4 deferred");
        cyc(1, 2, 0, 4'hF, 1, 2, 4, 4'hF, 32'h2222_0004, 0);
        chk_wr(1, 1, 3, "R4 retire next cycle");
        chk_wr(2, 0, 0, "R4 new deferral");
        cyc(1, 3, 0, 4'hF, 1, 3, 6, 4'hF, 32'h3333_0006, 0);
        chk_wr(2, 1, 4, "R4 pipeline");
        idle(1);
        chk_wr(3, 1, 6, "R4 pipeline tail");

        // R5: parked write blocked by read moves to older slot
        cyc(1, 1, 0, 4'hF, 1, 1, 7, 4'hF, 32'h4444_0007, 0);
        cyc(1, 1, 1, 4'hF, 1, 2, 8, 4'hF, 32'h5555_0008, 0);
        chk_wr(1, 0, 0, "R5 blocked by read");
        chk_wr(2, 1, 8, "R5 incoming direct");
        idle(1);
        chk_wr(1, 1, 7, "R5 older retires");

        // R5: two-group pattern, older write holds the group
        cyc(1, 0, 0, 4'hF, 1, 0, 9, 4'hF, 32'h6666_0009, 0);
        cyc(1, 1, 0, 4'hF, 1, 0, 10, 4'hF, 32'h7777_000A, 0);
        chk_wr(0, 1, 9, "R5 older first");
        cyc(1, 0, 0, 4'hF, 1, 1, 11, 4'hF, 32'h8888_000B, 0);
        chk_wr(0, 0, 0, "R5 second deferral");
        chk_wr(1, 1, 11, "R5 incoming direct");
        cyc(1, 1, 0, 4'hF, 1, 1, 12, 4'hF, 32'h9999_000C, 0);
        chk_wr(0, 1, 10, "R5 older slot retires");
        idle(1);
        chk_wr(1, 1, 12, "R4 next deferral retires");

        // R7: two pending writes to one row, newer wins, partial lanes
        cyc(0, 0, 0, '0, 1, 1, 2, 4'hF, 32'h0102_0304, 0);
        cyc(1, 1, 0, 4'hF, 1, 1, 2, 4'b0011, 32'hAAAA_BBBB, 0);
        cyc(1, 1, 0, 4'hF, 1, 1, 2, 4'b0110, 32'hCCCC_DDDD, 0);
        cyc(1, 1, 2, 4'hF, 0, 0, 0, '0, '0, 0);
        cyc(1, 1, 2, 4'b1010, 0, 0, 0, '0, '0, 0);
        idle(3);

        // R8: both slots stuck, third collision refused
        cyc(1, 0, 0, 4'hF, 1, 0, 13, 4'hF, 32'hDEAD_000D, 0);
        cyc(1, 0, 0, 4'hF, 1, 0, 14, 4'hF, 32'hDEAD_000E, 0);
        chk(!snap_busy, "R8 one slot free", {63'd0, snap_busy}, 64'd0);
        cyc(1, 0, 15, 4'hF, 1, 0, 15, 4'hF, 32'hDEAD_000F, 0);
        chk(snap_busy, "R8 busy when full", {63'd0, snap_busy}, 64'd1);
        chk(snap_wr == '0, "R8 nothing written", {60'd0, snap_wr}, 64'd0);

        // R9: drain refuses writes until the slots are empty
        cyc(0, 0, 0, '0, 1, 3, 1, 4'hF, 32'hBEEF_0001, 1);
        chk(snap_busy, "R9 drain refuses", {63'd0, snap_busy}, 64'd1);
        chk_wr(0, 1, 13, "R9 drain retire older");
        cyc(0, 0, 0, '0, 1, 3, 1, 4'hF, 32'hBEEF_0001, 1);
        chk(snap_busy, "R9 still pending", {63'd0, snap_busy}, 64'd1);
        chk_wr(0, 1, 14, "R9 drain retire newer");
        cyc(0, 0, 0, '0, 1, 3, 1, 4'hF, 32'hBEEF_0001, 1);
        chk(!snap_busy, "R9 drained", {63'd0, snap_busy}, 64'd0);
        chk_wr(3, 1, 1, "R9 write after drain");
        cyc(1, 0, 15, 4'hF, 0, 0, 0, '0, '0, 0);

        // near-exhaustive sweep over a small address space
        for (int i = 0; i < 4000; i++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            cyc(lf[2:0] != 0, int'(lf[4:3]), int'(lf[5]), lf[9:6],
                lf[12:10] != 0, int'(lf[14:13]), int'(lf[15]), lf[19:16],
                {lf[31:20], lf[19:0]} ^ 32'(i), lf[24:20] == 0);
        end
        cyc(0, 0, 0, '0, 0, 0, 0, '0, '0, 1);
        cyc(0, 0, 0, '0, 0, 0, 0, '0, '0, 1);
        idle(1);
        for (int g = 0; g < GROUPS; g++)
            for (int r = 0; r < ROWS; r++) cyc(1, g, r, 4'hF, 0, 0, 0, '0, '0, 0);
        idle(1);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule